// File: doc/BRIEF.md
# Load-Reserved / Store-Conditional Reservation Unit

This block keeps the single address reservation that a processor core needs for its load-reserved and store-conditional instructions, and it decides the outcome of every store-conditional. A load-reserved request stores its address and marks the reservation live. A separate cancel input clears it. A store-conditional request brings an address, an access width, store data and a translation pass/fault bit.

The block then checks the request in a fixed order. First it checks alignment for the access width. Next it checks the reservation match, then the legality of the access size, then translation. A request that passes every check becomes one memory write on a valid/ready request channel. A one-cycle response returns ok, fail or error. The outcome comes back as a one-cycle done strobe. The strobe carries either a destination-register value (0 for success, 1 for failure) or an exception code. The reservation is dropped after every write that completes with ok or fail.

Top module: `lrsc_resv_unit`

## Requirements
- R1: Width encoding on `sc_width`: 0 byte, 1 halfword, 2 word, 3 doubleword. A byte is always aligned. A halfword needs address bit 0 clear, a word needs bits 1:0 clear, and a doubleword needs bits 2:0 clear. A misaligned request raises exception code 6 with no memory write and no destination write.
- R2: The reservation matches only when it is live and its stored address equals `sc_addr` in full. An aligned request that does not match gives destination value 1 and issues no memory write.
- R3: `lr_valid` stores `lr_addr` and makes the reservation live, and `lr_cancel` clears it. When both arrive in the same cycle, the load-reserved wins. After reset the reservation is not live. The match uses the reservation as it stood before the edge that accepts the request.
- R4: An aligned, matching byte or halfword request raises exception code 2 (illegal size) and issues no write.
- R5: A matching, legal-size request with `sc_xlate_fault` high raises exception code 15 and issues no write.
- R6: The write request presents the address, `mem_req_dword`, and data. For a word, the data is the low 32 bits of `sc_data` zero-extended. The request stays valid and stable until `mem_req_ready` is seen.
- R7: A response with `mem_rsp_ok` high and `mem_rsp_fail` low gives destination value 0. Any other non-error response gives value 1. In both cases the reservation is cleared.
- R8: A response with `mem_rsp_err` high raises exception code 7, writes no destination value, and leaves the reservation unchanged.
- R9: `done` is high for one cycle per request, together with either `rd_we` or `exc_valid`, never both. An early outcome is due one cycle after acceptance, and a memory outcome one cycle after the response. `sc_ready` is low from acceptance until done.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| lr_valid | input | 1 | Load-reserved: record address |
| lr_addr | input | XLEN | Load-reserved address |
| lr_cancel | input | 1 | Clear the reservation |
| sc_valid | input | 1 | Store-conditional request |
| sc_ready | output | 1 | Unit idle, request accepted |
| sc_addr | input | XLEN | Store-conditional address |
| sc_width | input | 2 | Access width code |
| sc_data | input | XLEN | Store data |
| sc_xlate_fault | input | 1 | Translation of sc_addr faults |
| mem_req_valid | output | 1 | Write request valid |
| mem_req_ready | input | 1 | Write request taken |
| mem_req_addr | output | XLEN | Write address |
| mem_req_dword | output | 1 | 1 doubleword, 0 word |
| mem_req_data | output | XLEN | Write data |
| mem_rsp_valid | input | 1 | Write response valid |
| mem_rsp_ok | input | 1 | Conditional write succeeded |
| mem_rsp_fail | input | 1 | Conditional write failed |
| mem_rsp_err | input | 1 | Access exception |
| done | output | 1 | Outcome strobe |
| rd_we | output | 1 | Destination value valid |
| rd_value | output | XLEN | Destination value |
| exc_valid | output | 1 | Exception raised |
| exc_code | output | 5 | Exception cause |

## Verification
Every early outcome (misaligned, no match, illegal size, translation fault) is due in the cycle right after the accepting clock edge. The bench samples it at the next falling edge. A memory outcome is due one cycle after the edge that samples the response, and it is sampled the same way. Around each outcome the bench also checks that `done` is low in the following cycle. It checks that the write request stays stable through randomly long ready stalls. A bench model of the reservation predicts each outcome.

// File: rtl/lrsc_pkg.sv
package lrsc_pkg;
   typedef enum logic [1:0] {
      SZ_BYTE  = 2'd0,
      SZ_HALF  = 2'd1,
      SZ_WORD  = 2'd2,
      SZ_DWORD = 2'd3
   } sc_size_e;

   typedef enum logic [1:0] {
      ST_IDLE = 2'd0,
      ST_REQ  = 2'd1,
      ST_RSP  = 2'd2
   } sc_state_e;

   localparam int EXC_W = 5;
   localparam logic [EXC_W-1:0] EXC_ILLEGAL  = 5'd2;
   localparam logic [EXC_W-1:0] EXC_MISALIGN = 5'd6;
   localparam logic [EXC_W-1:0] EXC_ACCESS   = 5'd7;
   localparam logic [EXC_W-1:0] EXC_XLATE    = 5'd15;
endpackage

// File: rtl/lrsc_align_chk.sv
module lrsc_align_chk
   import lrsc_pkg::*;
#(
   parameter int XLEN = 64
) (
   input  logic [2:0] addr_lo_i,
   input  logic [1:0] width_i,
   output logic       aligned_o,
   output logic       legal_o
);
   sc_size_e size;
   assign size = sc_size_e'(width_i);

   always_comb begin
      case (size)
         SZ_BYTE:  aligned_o = 1'b1;
         SZ_HALF:  aligned_o = (addr_lo_i[0] == 1'b0);
         SZ_WORD:  aligned_o = (addr_lo_i[1:0] == 2'b00);
         default:  aligned_o = (addr_lo_i == 3'b000);
      endcase
   end

   generate
      if (XLEN == 64) begin : g_dw_legal
         assign legal_o = (size == SZ_WORD) || (size == SZ_DWORD);
      end else begin : g_w_only
         assign legal_o = (size == SZ_WORD);
      end
   endgenerate
endmodule

// File: rtl/lrsc_resv_reg.sv
module lrsc_resv_reg #(
   parameter int AW = 64
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          set_i,
   input  logic [AW-1:0] set_addr_i,
   input  logic          clr_i,
   input  logic [AW-1:0] cmp_addr_i,
   output logic          hit_o
);
   logic          live_q;
   logic [AW-1:0] addr_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         live_q <= 1'b0;
         addr_q <= '0;
      end else if (set_i) begin
         live_q <= 1'b1;
         addr_q <= set_addr_i;
      end else if (clr_i) begin
         live_q <= 1'b0;
      end
   end

   assign hit_o = live_q && (addr_q == cmp_addr_i);
endmodule

// File: rtl/lrsc_sc_ctrl.sv
module lrsc_sc_ctrl
   import lrsc_pkg::*;
#(
   parameter int XLEN = 64
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             sc_valid,
   input  logic [XLEN-1:0]  sc_addr,
   input  logic             sc_dword,
   input  logic [XLEN-1:0]  sc_data,
   input  logic             sc_xlate_fault,
   input  logic             aligned_i,
   input  logic             legal_i,
   input  logic             hit_i,
   output logic             sc_ready,
   output logic             mem_req_valid,
   input  logic             mem_req_ready,
   output logic [XLEN-1:0]  mem_req_addr,
   output logic             mem_req_dword,
   output logic [XLEN-1:0]  mem_req_data,
   input  logic             mem_rsp_valid,
   input  logic             mem_rsp_ok,
   input  logic             mem_rsp_fail,
   input  logic             mem_rsp_err,
   output logic             resv_clr_o,
   output logic             done,
   output logic             rd_we,
   output logic [XLEN-1:0]  rd_value,
   output logic             exc_valid,
   output logic [EXC_W-1:0] exc_code
);
   localparam int HALF = XLEN / 2;

   sc_state_e        st_q;
   logic [XLEN-1:0]  addr_q, data_q, shaped;
   logic             dw_q;
   logic             accept, rsp_take;

   generate
      if (XLEN == 64) begin : g_shape64
         assign shaped = sc_dword ? sc_data : {{HALF{1'b0}}, sc_data[HALF-1:0]};
      end else begin : g_shape32
         assign shaped = sc_data;
      end
   endgenerate

   assign accept     = (st_q == ST_IDLE) && sc_valid;
   assign rsp_take   = (st_q == ST_RSP) && mem_rsp_valid;
   assign resv_clr_o = rsp_take && !mem_rsp_err;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         st_q      <= ST_IDLE;
         addr_q    <= '0;
         data_q    <= '0;
         dw_q      <= 1'b0;
         done      <= 1'b0;
         rd_we     <= 1'b0;
         rd_value  <= '0;
         exc_valid <= 1'b0;
         exc_code  <= '0;
      end else begin
         done      <= 1'b0;
         rd_we     <= 1'b0;
         exc_valid <= 1'b0;
         case (st_q)
            ST_IDLE: if (accept) begin
               if (!aligned_i) begin
                  done <= 1'b1; exc_valid <= 1'b1; exc_code <= EXC_MISALIGN;
               end else if (!hit_i) begin
                  done <= 1'b1; rd_we <= 1'b1; rd_value <= XLEN'(1);
               end else if (!legal_i) begin
                  done <= 1'b1; exc_valid <= 1'b1; exc_code <= EXC_ILLEGAL;
               end else if (sc_xlate_fault) begin
                  done <= 1'b1; exc_valid <= 1'b1; exc_code <= EXC_XLATE;
               end else begin
                  st_q   <= ST_REQ;
                  addr_q <= sc_addr;
                  data_q <= shaped;
                  dw_q   <= sc_dword;
               end
            end
            ST_REQ: if (mem_req_ready) st_q <= ST_RSP;
            ST_RSP: if (rsp_take) begin
               st_q <= ST_IDLE;
               done <= 1'b1;
               if (mem_rsp_err) begin
                  exc_valid <= 1'b1; exc_code <= EXC_ACCESS;
               end else begin
                  rd_we    <= 1'b1;
                  rd_value <= (mem_rsp_ok && !mem_rsp_fail) ? '0 : XLEN'(1);
               end
            end
            default: st_q <= ST_IDLE;
         endcase
      end
   end

   assign sc_ready      = (st_q == ST_IDLE);
   assign mem_req_valid = (st_q == ST_REQ);
   assign mem_req_addr  = addr_q;
   assign mem_req_dword = dw_q;
   assign mem_req_data  = data_q;
endmodule

// File: rtl/lrsc_resv_unit.sv
module lrsc_resv_unit
   import lrsc_pkg::*;
#(
   parameter int XLEN = 64
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             lr_valid,
   input  logic [XLEN-1:0]  lr_addr,
   input  logic             lr_cancel,
   input  logic             sc_valid,
   output logic             sc_ready,
   input  logic [XLEN-1:0]  sc_addr,
   input  logic [1:0]       sc_width,
   input  logic [XLEN-1:0]  sc_data,
   input  logic             sc_xlate_fault,
   output logic             mem_req_valid,
   input  logic             mem_req_ready,
   output logic [XLEN-1:0]  mem_req_addr,
   output logic             mem_req_dword,
   output logic [XLEN-1:0]  mem_req_data,
   input  logic             mem_rsp_valid,
   input  logic             mem_rsp_ok,
   input  logic             mem_rsp_fail,
   input  logic             mem_rsp_err,
   output logic             done,
   output logic             rd_we,
   output logic [XLEN-1:0]  rd_value,
   output logic             exc_valid,
   output logic [EXC_W-1:0] exc_code
);
   generate
      if (XLEN != 32 && XLEN != 64) begin : g_bad_xlen
         $error("lrsc_resv_unit: XLEN must be 32 or 64");
      end
   endgenerate

   logic aligned, legal, hit, ctrl_clr;

   lrsc_align_chk #(.XLEN(XLEN)) u_align (
      .addr_lo_i (sc_addr[2:0]),
      .width_i   (sc_width),
      .aligned_o (aligned),
      .legal_o   (legal)
   );

   lrsc_resv_reg #(.AW(XLEN)) u_resv (
      .clk        (clk),
      .rst_n      (rst_n),
      .set_i      (lr_valid),
      .set_addr_i (lr_addr),
      .clr_i      (lr_cancel || ctrl_clr),
      .cmp_addr_i (sc_addr),
      .hit_o      (hit)
   );

   lrsc_sc_ctrl #(.XLEN(XLEN)) u_ctrl (
      .clk            (clk),
      .rst_n          (rst_n),
      .sc_valid       (sc_valid),
      .sc_addr        (sc_addr),
      .sc_dword       (sc_width == 2'(SZ_DWORD)),
      .sc_data        (sc_data),
      .sc_xlate_fault (sc_xlate_fault),
      .aligned_i      (aligned),
      .legal_i        (legal),
      .hit_i          (hit),
      .sc_ready       (sc_ready),
      .mem_req_valid  (mem_req_valid),
      .mem_req_ready  (mem_req_ready),
      .mem_req_addr   (mem_req_addr),
      .mem_req_dword  (mem_req_dword),
      .mem_req_data   (mem_req_data),
      .mem_rsp_valid  (mem_rsp_valid),
      .mem_rsp_ok     (mem_rsp_ok),
      .mem_rsp_fail   (mem_rsp_fail),
      .mem_rsp_err    (mem_rsp_err),
      .resv_clr_o     (ctrl_clr),
      .done           (done),
      .rd_we          (rd_we),
      .rd_value       (rd_value),
      .exc_valid      (exc_valid),
      .exc_code       (exc_code)
   );
endmodule

// File: rtl/lrsc_resv_unit_chk.sv
module lrsc_resv_unit_chk #(
   parameter int XLEN = 64
) (
   input logic            clk,
   input logic            rst_n,
   input logic            sc_ready,
   input logic            mem_req_valid,
   input logic            mem_req_ready,
   input logic [XLEN-1:0] mem_req_addr,
   input logic            mem_req_dword,
   input logic [XLEN-1:0] mem_req_data,
   input logic            done,
   input logic            rd_we,
   input logic [XLEN-1:0] rd_value,
   input logic            exc_valid
);
   // R9
   exc_only_on_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
      exc_valid |-> (done && !rd_we));

   // R7
   rd_is_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
      rd_we |-> (done && rd_value[XLEN-1:1] == '0));

   // R6
   req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_req_valid && !mem_req_ready) |=>
         (mem_req_valid && $stable(mem_req_addr) && $stable(mem_req_data) && $stable(mem_req_dword)));

   // R9
   busy_while_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
      mem_req_valid |-> !sc_ready);

   // R1
   req_aligned_chk: assert property (@(posedge clk) disable iff (!rst_n)
      mem_req_valid |-> (mem_req_dword ? (mem_req_addr[2:0] == 3'b000) : (mem_req_addr[1:0] == 2'b00)));
endmodule

bind lrsc_resv_unit lrsc_resv_unit_chk #(.XLEN(XLEN)) u_chk (
   .clk           (clk),
   .rst_n         (rst_n),
   .sc_ready      (sc_ready),
   .mem_req_valid (mem_req_valid),
   .mem_req_ready (mem_req_ready),
   .mem_req_addr  (mem_req_addr),
   .mem_req_dword (mem_req_dword),
   .mem_req_data  (mem_req_data),
   .done          (done),
   .rd_we         (rd_we),
   .rd_value      (rd_value),
   .exc_valid     (exc_valid)
);

// File: tb/lrsc_resv_unit_tb.sv
module lrsc_resv_unit_tb;
   localparam int CLK_PERIOD = 10;
   localparam int XLEN = 64;

   logic clk = 1'b0, rst_n = 1'b0;
   logic lr_valid = 0, lr_cancel = 0, sc_valid = 0, sc_xlate_fault = 0;
   logic [XLEN-1:0] lr_addr = '0, sc_addr = '0, sc_data = '0;
   logic [1:0] sc_width = 2'd2;
   logic mem_req_ready = 0, mem_rsp_valid = 0, mem_rsp_ok = 0, mem_rsp_fail = 0, mem_rsp_err = 0;
   logic sc_ready, mem_req_valid, mem_req_dword, done, rd_we, exc_valid;
   logic [XLEN-1:0] mem_req_addr, mem_req_data, rd_value;
   logic [4:0] exc_code;

   int checks = 0, errors = 0;
   bit finished = 0;
   bit mv = 0;
   logic [XLEN-1:0] ma = '0;

   always #(CLK_PERIOD/2) clk = ~clk;

   lrsc_resv_unit #(.XLEN(XLEN)) u_dut (.*);

   task automatic chk(input string tag, input logic [XLEN-1:0] got, input logic [XLEN-1:0] exp);
      checks++;
      if (got !== exp) begin
         errors++;
         $display("FAIL %s got %h exp %h", tag, got, exp);
      end
   endtask

   task automatic chk_early(input bit we, input logic [XLEN-1:0] val, input bit ev,
                            input logic [4:0] code, input string tag);
      chk({tag, " done"}, done, 1);
      chk({tag, " rd_we"}, rd_we, we);
      chk({tag, " exc_valid"}, exc_valid, ev);
      chk({tag, " no write"}, mem_req_valid, 0);
      if (we) chk({tag, " rd_value"}, rd_value, val);
      if (ev) chk({tag, " exc_code"}, exc_code, code);
   endtask

   task automatic do_lr(input logic [XLEN-1:0] a, input bit cancel);
      lr_valid = 1; lr_addr = a; lr_cancel = cancel;
      @(negedge clk);
      lr_valid = 0; lr_cancel = 0;
      mv = 1; ma = a;
   endtask

   task automatic do_cancel();
      lr_cancel = 1;
      @(negedge clk);
      lr_cancel = 0;
      mv = 0;
   endtask

   function automatic bit is_aligned(input logic [XLEN-1:0] a, input logic [1:0] w);
      case (w)
         2'd0: return 1;
         2'd1: return a[0] == 1'b0;
         2'd2: return a[1:0] == 2'b00;
         default: return a[2:0] == 3'b000;
      endcase
   endfunction

   function automatic logic [XLEN-1:0] exp_data(input logic [1:0] w, input logic [XLEN-1:0] d);
      return (w == 2'd3) ? d : {32'b0, d[31:0]};
   endfunction

   // rk: 0 ok, 1 fail, 2 err, 3 neither flag
   task automatic do_sc(input logic [XLEN-1:0] a, input logic [1:0] w, input logic [XLEN-1:0] d,
                        input bit f, input int rk, input int dly);
      bit hit;
      hit = mv && (ma == a);
      chk("R9 ready idle", sc_ready, 1);
      sc_valid = 1; sc_addr = a; sc_width = w; sc_data = d; sc_xlate_fault = f;
      @(negedge clk);
      sc_valid = 0; sc_xlate_fault = 0;
      if (!is_aligned(a, w))      chk_early(0, 0, 1, 5'd6, "R1 misaligned");
      else if (!hit)              chk_early(1, 1, 0, 0, "R2 no match");
      else if (w < 2'd2)          chk_early(0, 0, 1, 5'd2, "R4 illegal size");
      else if (f)                 chk_early(0, 0, 1, 5'd15, "R5 xlate fault");
      else begin
         chk("R6 req valid", mem_req_valid, 1);
         chk("R6 req addr", mem_req_addr, a);
         chk("R6 req dword", mem_req_dword, (w == 2'd3));
         chk("R6 req data", mem_req_data, exp_data(w, d));
         chk("R9 busy", sc_ready, 0);
         chk("R9 no early done", done, 0);
         for (int i = 0; i < dly; i++) begin
            @(negedge clk);
            chk("R6 held valid", mem_req_valid, 1);
            chk("R6 held addr", mem_req_addr, a);
         end
         mem_req_ready = 1;
         @(negedge clk);
         mem_req_ready = 0;
         chk("R6 req dropped", mem_req_valid, 0);
         mem_rsp_valid = 1;
         mem_rsp_ok = (rk == 0); mem_rsp_fail = (rk == 1); mem_rsp_err = (rk == 2);
         @(negedge clk);
         mem_rsp_valid = 0; mem_rsp_ok = 0; mem_rsp_fail = 0; mem_rsp_err = 0;
         if (rk == 2) chk_early(0, 0, 1, 5'd7, "R8 access err");
         else begin
            chk_early(1, (rk == 0) ? 0 : 1, 0, 0, "R7 write result");
            mv = 0;
         end
      end
      @(negedge clk);
      chk("R9 done one cycle", done, 0);
   endtask

   function automatic logic [XLEN-1:0] pick_addr();
      logic [XLEN-1:0] b;
      b = 64'h8000_0000 + 64'(($urandom % 6) * 8);
      if ($urandom % 4 == 0) b = b + 64'($urandom % 8);
      return b;
   endfunction

   initial begin
      repeat (200000) @(posedge clk);
      if (!finished) begin
         errors++;
         $display("FAIL watchdog expired");
         $display("  CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   initial begin
      void'($urandom(32'd4242));
      repeat (3) @(negedge clk);
      rst_n = 1;
      @(negedge clk);
      chk("R9 reset done", done, 0);
      chk("R9 reset no req", mem_req_valid, 0);
      chk("R9 reset ready", sc_ready, 1);
      // R3: reservation not live after reset
      do_sc(64'h1000, 2'd2, 64'h1, 0, 0, 0);

      // R1 misaligned per width
      do_lr(64'h1001, 0);
      do_sc(64'h1001, 2'd1, 64'h5, 0, 0, 0);
      do_sc(64'h1002, 2'd2, 64'h5, 0, 0, 0);
      do_lr(64'h1004, 0);
      do_sc(64'h1004, 2'd3, 64'h5, 0, 0, 0);
      // R4 byte aligned and matching but illegal size
      do_lr(64'h1003, 0);
      do_sc(64'h1003, 2'd0, 64'h5, 0, 0, 0);
      // R3 cancel clears
      do_lr(64'h2000, 0);
      do_cancel();
      do_sc(64'h2000, 2'd2, 64'h7, 0, 0, 0);
      // R3 set wins over cancel
      do_lr(64'h2000, 1);
      // R6 word data zero-extended, R7 success clears reservation
      do_sc(64'h2000, 2'd2, 64'hDEAD_BEEF_1234_5678, 0, 0, 2);
      do_sc(64'h2000, 2'd2, 64'h1, 0, 0, 0);
      // R5 fault keeps nothing written
      do_lr(64'h3000, 0);
      do_sc(64'h3000, 2'd3, 64'h9, 1, 0, 0);
      // R8 error keeps reservation; then R7 fail result
      do_sc(64'h3000, 2'd3, 64'hAAAA_BBBB_CCCC_DDDD, 0, 2, 1);
      do_sc(64'h3000, 2'd3, 64'h11, 0, 1, 0);
      do_lr(64'h3008, 0);
      do_sc(64'h3008, 2'd3, 64'h22, 0, 3, 0);

      for (int n = 0; n < 400; n++) begin
         int op;
         op = $urandom % 10;
         if (op < 3) do_lr(pick_addr(), ($urandom % 4) == 0);
         else if (op == 3) do_cancel();
         else begin
            logic [XLEN-1:0] a;
            logic [1:0] w;
            a = (mv && ($urandom % 3 != 0)) ? ma : pick_addr();
            w = ($urandom % 4 == 0) ? 2'($urandom % 2) : 2'(2 + $urandom % 2);
            do_sc(a, w, {$urandom, $urandom}, ($urandom % 8) == 0, int'($urandom % 4), int'($urandom % 4));
         end
      end

      finished = 1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule